// File: doc/BRIEF.md
# Operand Address Decoder for a ModR/M Byte

This block turns an instruction's ModR/M byte into the operand location for a one-operand memory access. It splits the byte into its mode, register/subop and r/m fields. It reads the base register through a read port into an eight-entry, 32-bit register file. It then pulls any displacement bytes it needs from the instruction byte stream.

A request is a one-cycle `start` pulse with the ModR/M byte. The block answers with a one-cycle `done` pulse. With `done` it gives:

- the register/subop field;
- whether the operand lives in memory;
- the 32-bit effective address;
- how many displacement bytes it took, so the fetch logic can advance the instruction pointer.

Requests that need no displacement finish one cycle after `start`. The others wait for stream bytes, one byte per cycle at most.

Top module: `modrm_eagen`

## Requirements
- R1: At `done`, `reg_fld` equals bits 5:3 of the ModR/M byte given with `start`. Bits 7:6 are the mode and bits 2:0 are the r/m field.
- R2: Mode 11 (register operand) gives `done` one cycle after `start`. The results are `mem_op`=0, `eaddr`=0, `disp_len`=0 and `bad_mode`=0, and no stream byte is taken.
- R3: Mode 00 with an r/m field other than 4 or 5 gives `done` one cycle after `start`. `eaddr` is the register-file word selected by r/m, and `rf_sel` follows `modrm[2:0]`.
- R4: Mode 00 with r/m=5 takes four stream bytes. The first byte is the least significant. The bytes form the absolute address and the register file is not used: bytes 60 00 00 00 give 0x60.
- R5: Mode 01 takes one stream byte. It is sign-extended and added to the r/m register: 0x5e plus 0x02 and 0x61 plus 0xff both give 0x60.
- R6: Mode 10 takes four stream bytes, least significant first. They are added to the r/m register modulo 2^32: 0x61 plus 0xffffffff gives 0x60.
- R7: A memory mode (00, 01 or 10) with r/m=4 gives `done` one cycle after `start`. The results are `bad_mode`=1, `mem_op`=1, `eaddr`=0 and `disp_len`=0, and no stream byte is taken.
- R8: `disp_len` is 0, 1 or 4, and exactly that many bytes are popped. `strm_pop` is high only while `strm_valid` is high. `done` rises in the cycle after the last pop.
- R9: While `busy` is high, `start` is ignored and no second `done` results. An empty stream stalls the request without losing its state.
- R10: After reset, `done`, `busy`, `strm_pop`, `mem_op`, `bad_mode`, `eaddr`, `disp_len` and `reg_fld` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin decoding `modrm` (ignored while busy) |
| modrm | input | 8 | ModR/M byte |
| rf_sel | output | 3 | Register-file read index (r/m field) |
| rf_data | input | 32 | Register-file read data |
| strm_valid | input | 1 | Instruction stream byte available |
| strm_byte | input | 8 | Instruction stream byte |
| strm_pop | output | 1 | Stream byte consumed this cycle |
| busy | output | 1 | Waiting for displacement bytes |
| done | output | 1 | One-cycle result strobe |
| reg_fld | output | 3 | Register/subop field |
| mem_op | output | 1 | Operand is in memory |
| eaddr | output | 32 | Effective address |
| disp_len | output | 3 | Displacement bytes consumed (0, 1, 4) |
| bad_mode | output | 1 | Memory mode that needs a SIB byte (unsupported) |

## Verification
Two kinds of internal fault show up at the ports. A wrong byte counter or a wrong byte-lane position shows as the wrong number of pops, or as an address with bytes in the wrong lanes, seen at the `done` of that same request. A sign-extension or base-capture error shows only in the address sum, so directed cases with small negative displacements and large register values are paired with random stimulus. A stuck busy state shows as a missing `done` within a few cycles, or as an extra `done` after a `start` that arrived mid-request.

// File: rtl/modrm_eagen.sv
module modrm_eagen #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        modrm,
  output logic [IDX_W-1:0]  rf_sel,
  input  logic [ADDR_W-1:0] rf_data,
  input  logic              strm_valid,
  input  logic [7:0]        strm_byte,
  output logic              strm_pop,
  output logic              busy,
  output logic              done,
  output logic [IDX_W-1:0]  reg_fld,
  output logic              mem_op,
  output logic [ADDR_W-1:0] eaddr,
  output logic [2:0]        disp_len,
  output logic              bad_mode
);
  localparam logic [1:0] MOD_IND  = 2'b00;
  localparam logic [1:0] MOD_D8   = 2'b01;
  localparam logic [1:0] MOD_REG  = 2'b11;
  localparam logic [2:0] RM_SIB   = 3'd4;
  localparam logic [2:0] RM_ABS   = 3'd5;
  localparam logic [2:0] LEN_WIDE = 3'(ADDR_W / 8);

  logic              fetch_q;
  logic [IDX_W-1:0]  reg_q;
  logic [ADDR_W-1:0] base_q, disp_q, disp_nxt, disp_ext;
  logic [2:0]        need_q, cnt_q;
  logic              last;

  wire [1:0] mod_in = modrm[7:6];
  wire [2:0] rm_in  = modrm[2:0];

  assign rf_sel   = rm_in[IDX_W-1:0];
  assign busy     = fetch_q;
  assign strm_pop = fetch_q & strm_valid;
  assign disp_nxt = disp_q | (ADDR_W'(strm_byte) << {cnt_q, 3'b000});
  assign last     = strm_pop && (cnt_q + 3'd1 == need_q);
  assign disp_ext = (need_q == 3'd1) ? {{(ADDR_W-8){disp_nxt[7]}}, disp_nxt[7:0]} : disp_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_q  <= 1'b0;
      reg_q    <= '0;
      base_q   <= '0;
      disp_q   <= '0;
      need_q   <= '0;
      cnt_q    <= '0;
      done     <= 1'b0;
      reg_fld  <= '0;
      mem_op   <= 1'b0;
      eaddr    <= '0;
      disp_len <= '0;
      bad_mode <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!fetch_q && start) begin
        if (mod_in == MOD_REG) begin
          done     <= 1'b1;
          reg_fld  <= modrm[3 +: IDX_W];
          mem_op   <= 1'b0;
          eaddr    <= '0;
          disp_len <= '0;
          bad_mode <= 1'b0;
        end else if (rm_in == RM_SIB) begin
          done     <= 1'b1;
          reg_fld  <= modrm[3 +: IDX_W];
          mem_op   <= 1'b1;
          eaddr    <= '0;
          disp_len <= '0;
          bad_mode <= 1'b1;
        end else if (mod_in == MOD_IND && rm_in != RM_ABS) begin
          done     <= 1'b1;
          reg_fld  <= modrm[3 +: IDX_W];
          mem_op   <= 1'b1;
          eaddr    <= rf_data;
          disp_len <= '0;
          bad_mode <= 1'b0;
        end else begin
          fetch_q <= 1'b1;
          reg_q   <= modrm[3 +: IDX_W];
          base_q  <= (mod_in == MOD_IND) ? '0 : rf_data;
          need_q  <= (mod_in == MOD_D8) ? 3'd1 : LEN_WIDE;
          cnt_q   <= '0;
          disp_q  <= '0;
        end
      end else if (strm_pop) begin
        disp_q <= disp_nxt;
        cnt_q  <= cnt_q + 3'd1;
        if (last) begin
          fetch_q  <= 1'b0;
          done     <= 1'b1;
          reg_fld  <= reg_q;
          mem_op   <= 1'b1;
          eaddr    <= base_q + disp_ext;
          disp_len <= need_q;
          bad_mode <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/modrm_eagen_chk.sv
module modrm_eagen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        strm_valid,
  input logic        strm_pop,
  input logic        busy,
  input logic        done,
  input logic        mem_op,
  input logic [31:0] eaddr,
  input logic [2:0]  disp_len,
  input logic        bad_mode
);
  a_r8_pop_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    strm_pop |-> strm_valid);

  a_r8_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (disp_len == 3'd0 || disp_len == 3'd1 || disp_len == 3'd4));

  a_r8_done_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (done && disp_len != 3'd0) |-> $past(strm_pop));

  a_r2_reg_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mem_op) |-> (disp_len == 3'd0 && !bad_mode && eaddr == 32'd0));

  a_r7_bad_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bad_mode) |-> (mem_op && disp_len == 3'd0 && eaddr == 32'd0));

  a_r9_idle_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !strm_pop);

  a_r9_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_busy_no_done_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !strm_pop) |=> !done);
endmodule

bind modrm_eagen modrm_eagen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .strm_valid(strm_valid),
  .strm_pop(strm_pop), .busy(busy), .done(done), .mem_op(mem_op),
  .eaddr(eaddr), .disp_len(disp_len), .bad_mode(bad_mode)
);

// File: tb/modrm_eagen_tb_top.sv
`timescale 1ns/1ps
module modrm_eagen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] modrm = 8'h00;
  logic [2:0] rf_sel;
  logic [31:0] rf_data;
  logic strm_valid, strm_pop, busy, done, mem_op, bad_mode;
  logic [7:0] strm_byte;
  logic [2:0] reg_fld, disp_len;
  logic [31:0] eaddr;

  logic [31:0] rfile [8];
  logic [7:0]  sbuf [4];
  int unsigned sidx = 0;
  logic gate = 1'b1;
  logic hold = 1'b0;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  assign rf_data    = rfile[rf_sel];
  assign strm_valid = (sidx < 4) && gate && !hold;
  assign strm_byte  = (sidx < 4) ? sbuf[sidx[1:0]] : 8'h00;

  always @(posedge clk) if (strm_pop) sidx <= sidx + 1;

  modrm_eagen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .modrm(modrm), .rf_sel(rf_sel),
    .rf_data(rf_data), .strm_valid(strm_valid), .strm_byte(strm_byte),
    .strm_pop(strm_pop), .busy(busy), .done(done), .reg_fld(reg_fld),
    .mem_op(mem_op), .eaddr(eaddr), .disp_len(disp_len), .bad_mode(bad_mode)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_len(input logic [7:0] m);
    if (m[7:6] == 2'b11 || m[2:0] == 3'd4) return 3'd0;
    if (m[7:6] == 2'b01) return 3'd1;
    if (m[7:6] == 2'b10 || m[2:0] == 3'd5) return 3'd4;
    return 3'd0;
  endfunction

  function automatic logic [31:0] exp_addr(input logic [7:0] m, input logic [31:0] d);
    logic [31:0] r;
    r = rfile[m[2:0]];
    if (m[7:6] == 2'b11 || m[2:0] == 3'd4) return 32'd0;
    if (m[7:6] == 2'b01) return r + {{24{d[7]}}, d[7:0]};
    if (m[7:6] == 2'b10) return r + d;
    if (m[2:0] == 3'd5) return d;
    return r;
  endfunction

  task automatic load_stream(input logic [31:0] d);
    sbuf[0] = d[7:0];   sbuf[1] = d[15:8];
    sbuf[2] = d[23:16]; sbuf[3] = d[31:24];
    sidx = 0;
  endtask

  task automatic check_result(input logic [7:0] m, input logic [31:0] d, input string tag);
    logic [2:0] el;
    el = exp_len(m);
    chk(reg_fld == m[5:3], {tag, " R1 reg field"}, 32'(reg_fld), 32'(m[5:3]));
    chk(mem_op == (m[7:6] != 2'b11), {tag, " R2 mem flag"}, 32'(mem_op), 32'(m[7:6] != 2'b11));
    chk(bad_mode == (m[7:6] != 2'b11 && m[2:0] == 3'd4), {tag, " R7 bad mode"}, 32'(bad_mode),
        32'(m[7:6] != 2'b11 && m[2:0] == 3'd4));
    chk(eaddr == exp_addr(m, d), {tag, " R3/R4/R5/R6 address"}, eaddr, exp_addr(m, d));
    chk(disp_len == el, {tag, " R8 length"}, 32'(disp_len), 32'(el));
    chk(sidx == el, {tag, " R8 pops"}, sidx, 32'(el));
  endtask

  task automatic run_op(input logic [7:0] m, input logic [31:0] d, input string tag);
    int n;
    load_stream(d);
    @(negedge clk);
    modrm = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0; modrm = $urandom;
    n = 1;
    while (!done && n < 50) begin
      gate = ($urandom % 4) != 0;
      @(negedge clk);
      n++;
    end
    gate = 1'b1;
    chk(done, {tag, " R8 done seen"}, 32'(done), 32'd1);
    if (exp_len(m) == 3'd0)
      chk(n == 1, {tag, " R2/R3/R7 one-cycle latency"}, n, 32'd1);
    check_result(m, d, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) rfile[i] = 32'h1000 * (i + 1);
    repeat (3) @(negedge clk);
    chk(!done && !busy && !strm_pop && !mem_op && !bad_mode, "R10 reset flags", 32'(done), 32'd0);
    chk(eaddr == 0 && disp_len == 0 && reg_fld == 0, "R10 reset values", eaddr, 32'd0);
    rst_n = 1'b1;

    rfile[0] = 32'h60; rfile[3] = 32'h10;
    run_op(8'h18, 32'hdeadbeef, "indirect EAX");
    run_op(8'h1d, 32'h00000060, "R4 absolute");
    rfile[0] = 32'h5e;
    run_op(8'h58, 32'h00000002, "R5 disp8 pos");
    rfile[0] = 32'h61;
    run_op(8'h58, 32'h000000ff, "R5 disp8 neg");
    run_op(8'h98, 32'hffffffff, "R6 disp32 wrap");
    run_op(8'hc3, 32'h12345678, "R2 register");
    run_op(8'h04, 32'h12345678, "R7 sib mod0");
    run_op(8'h44, 32'h12345678, "R7 sib mod1");
    run_op(8'h84, 32'h12345678, "R7 sib mod2");

    rfile[2] = 32'h100;
    load_stream(32'h00000020);
    hold = 1'b1;
    @(negedge clk); modrm = 8'h9a; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy && !done, "R9 stalled busy", 32'(busy), 32'd1);
    modrm = 8'hc0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!done && sidx == 0, "R9 start ignored while busy", 32'(done), 32'd0);
    hold = 1'b0;
    while (!done) @(negedge clk);
    chk(reg_fld == 3'd3 && mem_op && eaddr == 32'h120, "R9 first request kept", eaddr, 32'h120);
    chk(sidx == 4, "R9 pops after stall", sidx, 32'd4);
    repeat (2) @(negedge clk);
    chk(!done, "R9 no second done", 32'(done), 32'd0);

    for (int k = 0; k < 120; k++) begin
      for (int i = 0; i < 8; i++) rfile[i] = $urandom;
      run_op(8'($urandom), $urandom, "random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule